// File: doc/BRIEF.md
# MESI Cache Line State Controller

This block tracks the coherence state of a small, direct-mapped set of cache lines belonging to one processor node on a shared memory bus. Each line holds one of four states (modified, exclusive, shared, invalid) and a stored tag. The policy is write-back. Local reads and writes come from the node's own processor. Snooped operations come from other nodes and are either a read or a write-through/invalidate broadcast. For every accepted operation the controller updates the addressed line's state. It also issues the bus action that the operation needs: none, line fill, write-through or write-back.

The policy differs from textbook MESI in two ways. A local write to a shared line is written through to memory, and the line moves to exclusive, not to modified. A local write miss is written through and does not allocate a line.

When another node's read hits a dirty line, the controller tells that node to retry. It then writes the line back before the node's fill can succeed. Tags are matched by a plain compare of the upper line-address bits. The low bits select the line.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is invalid. In the first cycle after reset, loc_ack, snp_ack, snp_retry and bus_valid are all low.
- R2: Line states are reported on loc_state as 00 invalid, 01 shared, 10 exclusive, 11 modified. Bus actions on bus_op are 00 none, 01 line fill, 10 write-through, 11 write-back, and bus_op is 00 whenever bus_valid is low.
- R3: A local read that hits a modified, exclusive or shared line leaves the state unchanged and issues no bus action.
- R4: A local write hit behaves by state:
  - on an exclusive line it sets the line to modified, with no bus action;
  - on a modified line it keeps the line modified, with no bus action;
  - on a shared line it issues a write-through of the request address and sets the line to exclusive.
- R5: A local read miss issues a line fill of the request address and installs the line as exclusive. If the indexed line is modified under another tag, a write-back of that victim is issued first, and the fill follows in the next cycle.
- R6: A local write miss issues a write-through of the request address and reports invalid (00). It allocates nothing and leaves the line held at that index unchanged.
- R7: A snooped read that hits an exclusive or shared line leaves it shared, with no bus action and no retry. A snoop that misses changes nothing.
- R8: A snooped read that hits a modified line makes it shared and raises snp_retry. That happens with snp_ack in the cycle after acceptance and again in the following cycle. In that following cycle a write-back of the line's address is issued.
- R9: A snooped invalidate (snp_inval=1) that hits a line in any valid state makes the line invalid.
- R10: A snoop takes priority over a local request in the same cycle. loc_stall is high while loc_valid is high and either a snoop is presented or a write-back is pending. A stalled request is not acknowledged, and it is served once the stall drops.
- R11: A snoop presented while a write-back is pending is not processed. It is answered with snp_retry in the next cycle, with snp_ack low.
- R12: Responses (loc_ack, loc_hit, loc_state, snp_ack, snp_hit, snp_retry and the bus action) appear in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local request present |
| loc_write | input | 1 | Local request is a write (0 = read) |
| loc_addr | input | ADDR_W | Local line address |
| loc_stall | output | 1 | Local request not accepted this cycle |
| loc_ack | output | 1 | Local request completed (one cycle after acceptance) |
| loc_hit | output | 1 | Completed local request hit |
| loc_state | output | 2 | State of the addressed line after the local request |
| snp_valid | input | 1 | Snooped bus operation present |
| snp_inval | input | 1 | Snoop is a write-through/invalidate (0 = read) |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_ack | output | 1 | Snoop was processed |
| snp_hit | output | 1 | Processed snoop hit a valid line |
| snp_retry | output | 1 | Snooping requester must delay and retry |
| bus_valid | output | 1 | Bus action issued this cycle |
| bus_op | output | 2 | Bus action code |
| bus_addr | output | ADDR_W | Line address of the bus action |

## Verification
The hardest situation to reach is the window between a snoop hitting a modified line and its write-back. Only during that window can a second snoop be refused and a local request held by the pending write-back rather than by a snoop. The stimulus first makes a line modified through a read fill and a local write. It then presents a snooped read, and on the very next cycle drives a second snoop and a local read to the same line together. The same reasoning applies to the victim write-back on a conflicting read miss. There the dirty line is built up first, and a read with a different tag at the same index is issued.

// File: rtl/mesi_ctrl_pkg.sv
package mesi_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_SHR = 2'b01,
        ST_EXC = 2'b10,
        ST_MOD = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        BUS_NONE  = 2'b00,
        BUS_FILL  = 2'b01,
        BUS_WTHRU = 2'b10,
        BUS_WBACK = 2'b11
    } bus_op_e;

    // Outcome of a local access on the indexed line
    typedef struct packed {
        line_state_e next;    // value to store when store is set
        logic        store;
        bus_op_e     op;
        line_state_e report;  // state seen by the requester afterwards
    } local_step_t;

    // Outcome of a snooped access on the indexed line
    typedef struct packed {
        line_state_e next;
        logic        store;
        logic        wback;   // dirty hit: delay requester, write line back
    } snoop_step_t;

    function automatic local_step_t local_step(line_state_e cur, logic hit, logic is_wr);
        local_step_t s;
        s.next   = cur;
        s.store  = 1'b0;
        s.op     = BUS_NONE;
        s.report = cur;
        if (!hit) begin
            if (is_wr) begin
                s.op     = BUS_WTHRU;
                s.report = ST_INV;
            end else begin
                s.next   = ST_EXC;
                s.store  = 1'b1;
                s.op     = BUS_FILL;
                s.report = ST_EXC;
            end
        end else if (is_wr) begin
            case (cur)
                ST_EXC: begin
                    s.next  = ST_MOD;
                    s.store = 1'b1;
                end
                ST_SHR: begin
                    s.next  = ST_EXC;
                    s.store = 1'b1;
                    s.op    = BUS_WTHRU;
                end
                default: ;
            endcase
            s.report = s.next;
        end
        return s;
    endfunction

    function automatic snoop_step_t snoop_step(line_state_e cur, logic hit, logic is_inv);
        snoop_step_t s;
        s.next  = cur;
        s.store = 1'b0;
        s.wback = 1'b0;
        if (hit) begin
            s.store = 1'b1;
            if (is_inv) begin
                s.next = ST_INV;
            end else begin
                s.next  = ST_SHR;
                s.wback = (cur == ST_MOD);
            end
        end
        return s;
    endfunction

    function automatic logic victim_dirty(line_state_e cur, logic hit, logic is_wr);
        return !hit && !is_wr && (cur == ST_MOD);
    endfunction

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
    import mesi_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 9,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output line_state_e       rd_state,
    output logic [TAG_W-1:0]  rd_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_state_e       wr_state,
    input  logic [TAG_W-1:0]  wr_tag
);

    line_state_e      st_vec  [NUM_LINES];
    logic [TAG_W-1:0] tag_vec [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_state_e      st_r;
        logic [TAG_W-1:0] tag_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_r  <= ST_INV;
                tag_r <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                st_r  <= wr_state;
                tag_r <= wr_tag;
            end
        end

        assign st_vec[g]  = st_r;
        assign tag_vec[g] = tag_r;
    end

    assign rd_state = st_vec[rd_idx];
    assign rd_tag   = tag_vec[rd_idx];

endmodule

// File: rtl/mesi_arbiter.sv
module mesi_arbiter (
    input  logic snp_valid,
    input  logic loc_valid,
    input  logic wb_pending,
    output logic take_snoop,
    output logic take_local,
    output logic loc_stall,
    output logic snp_refused
);

    // A pending write-back owns the cycle; otherwise a snoop beats a local request
    assign take_snoop  = snp_valid && !wb_pending;
    assign take_local  = loc_valid && !snp_valid && !wb_pending;
    assign loc_stall   = loc_valid && (snp_valid || wb_pending);
    assign snp_refused = snp_valid && wb_pending;

endmodule

// File: rtl/mesi_txn_engine.sv
module mesi_txn_engine
    import mesi_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 8,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_snoop,
    input  logic              take_local,
    input  logic              snp_refused,
    input  logic              snp_inval,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              loc_write,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic              wb_pending,
    output logic [IDX_W-1:0]  look_idx,
    input  line_state_e       rd_state,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              wr_en,
    output line_state_e       wr_state,
    output logic [TAG_W-1:0]  wr_tag,
    output logic              loc_ack,
    output logic              loc_hit,
    output line_state_e       loc_state,
    output logic              snp_ack,
    output logic              snp_hit,
    output logic              snp_retry,
    output logic              bus_valid,
    output bus_op_e           bus_op,
    output logic [ADDR_W-1:0] bus_addr
);

    typedef struct packed {
        logic              valid;
        bus_op_e           op;
        logic              retry;
        logic [ADDR_W-1:0] addr;
    } pend_t;

    pend_t             pend_q;
    logic [ADDR_W-1:0] look_addr;
    logic [TAG_W-1:0]  look_tag;
    logic              hit;
    local_step_t       lstep;
    snoop_step_t       sstep;
    logic              victim_wb;

    always_comb begin
        look_addr = take_snoop ? snp_addr : loc_addr;
        look_idx  = look_addr[IDX_W-1:0];
        look_tag  = look_addr[ADDR_W-1:IDX_W];
        hit       = (rd_state != ST_INV) && (rd_tag == look_tag);
        lstep     = local_step(rd_state, hit, loc_write);
        sstep     = snoop_step(rd_state, hit, snp_inval);
        victim_wb = victim_dirty(rd_state, hit, loc_write);
        wr_en     = (take_snoop && sstep.store) || (take_local && lstep.store);
        wr_state  = take_snoop ? sstep.next : lstep.next;
        wr_tag    = look_tag;
    end

    assign wb_pending = pend_q.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            loc_ack   <= 1'b0;
            loc_hit   <= 1'b0;
            loc_state <= ST_INV;
            snp_ack   <= 1'b0;
            snp_hit   <= 1'b0;
            snp_retry <= 1'b0;
            bus_valid <= 1'b0;
            bus_op    <= BUS_NONE;
            bus_addr  <= '0;
        end else begin
            pend_q.valid <= 1'b0;
            loc_ack      <= 1'b0;
            snp_ack      <= 1'b0;
            snp_retry    <= 1'b0;
            bus_valid    <= 1'b0;
            bus_op       <= BUS_NONE;
            if (pend_q.valid) begin
                bus_valid <= 1'b1;
                bus_op    <= pend_q.op;
                bus_addr  <= pend_q.addr;
                snp_retry <= pend_q.retry || snp_refused;
            end else if (take_snoop) begin
                snp_ack <= 1'b1;
                snp_hit <= hit;
                if (sstep.wback) begin
                    snp_retry <= 1'b1;
                    pend_q    <= '{valid: 1'b1, op: BUS_WBACK, retry: 1'b1, addr: snp_addr};
                end
            end else if (take_local) begin
                loc_ack   <= 1'b1;
                loc_hit   <= hit;
                loc_state <= lstep.report;
                if (victim_wb) begin
                    bus_valid <= 1'b1;
                    bus_op    <= BUS_WBACK;
                    bus_addr  <= {rd_tag, look_idx};
                    pend_q    <= '{valid: 1'b1, op: BUS_FILL, retry: 1'b0, addr: loc_addr};
                end else if (lstep.op != BUS_NONE) begin
                    bus_valid <= 1'b1;
                    bus_op    <= lstep.op;
                    bus_addr  <= loc_addr;
                end
            end
        end
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loc_valid,
    input  logic              loc_write,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic              loc_stall,
    output logic              loc_ack,
    output logic              loc_hit,
    output logic [1:0]        loc_state,
    input  logic              snp_valid,
    input  logic              snp_inval,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_ack,
    output logic              snp_hit,
    output logic              snp_retry,
    output logic              bus_valid,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic             take_snoop, take_local, snp_refused, wb_pending;
    logic [IDX_W-1:0] look_idx;
    line_state_e      rd_state, wr_state, loc_state_e;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic             wr_en;
    bus_op_e          bus_op_e_q;

    mesi_arbiter u_arb (
        .snp_valid  (snp_valid),
        .loc_valid  (loc_valid),
        .wb_pending (wb_pending),
        .take_snoop (take_snoop),
        .take_local (take_local),
        .loc_stall  (loc_stall),
        .snp_refused(snp_refused)
    );

    mesi_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (look_idx),
        .rd_state(rd_state),
        .rd_tag  (rd_tag),
        .wr_en   (wr_en),
        .wr_idx  (look_idx),
        .wr_state(wr_state),
        .wr_tag  (wr_tag)
    );

    mesi_txn_engine #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .take_snoop (take_snoop),
        .take_local (take_local),
        .snp_refused(snp_refused),
        .snp_inval  (snp_inval),
        .snp_addr   (snp_addr),
        .loc_write  (loc_write),
        .loc_addr   (loc_addr),
        .wb_pending (wb_pending),
        .look_idx   (look_idx),
        .rd_state   (rd_state),
        .rd_tag     (rd_tag),
        .wr_en      (wr_en),
        .wr_state   (wr_state),
        .wr_tag     (wr_tag),
        .loc_ack    (loc_ack),
        .loc_hit    (loc_hit),
        .loc_state  (loc_state_e),
        .snp_ack    (snp_ack),
        .snp_hit    (snp_hit),
        .snp_retry  (snp_retry),
        .bus_valid  (bus_valid),
        .bus_op     (bus_op_e_q),
        .bus_addr   (bus_addr)
    );

    assign loc_state = loc_state_e;
    assign bus_op    = bus_op_e_q;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              loc_valid,
    input logic              loc_stall,
    input logic [ADDR_W-1:0] loc_addr,
    input logic              loc_ack,
    input logic              loc_hit,
    input logic [1:0]        loc_state,
    input logic              snp_ack,
    input logic              snp_retry,
    input logic              bus_valid,
    input logic [1:0]        bus_op,
    input logic [ADDR_W-1:0] bus_addr
);

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!bus_valid && !loc_ack && !snp_ack && !snp_retry));

    a_r2_no_op_when_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (bus_op == 2'b00));

    a_r3_silent_hit: assert property (@(posedge clk) disable iff (rst)
        (loc_ack && loc_hit && (loc_state == 2'b11 || loc_state == 2'b01)) |-> !bus_valid);

    a_r5_fill_on_read_miss: assert property (@(posedge clk) disable iff (rst)
        (loc_ack && !loc_hit && loc_state == 2'b10) |-> (bus_valid && (bus_op == 2'b01 || bus_op == 2'b11)));

    a_r6_write_miss_through: assert property (@(posedge clk) disable iff (rst)
        (loc_ack && !loc_hit && loc_state == 2'b00) |-> (bus_valid && bus_op == 2'b10 && bus_addr == $past(loc_addr)));

    a_r8_wback_after_retry: assert property (@(posedge clk) disable iff (rst)
        (snp_ack && snp_retry) |=> (bus_valid && bus_op == 2'b11 && snp_retry));

    a_r10_stall_no_ack: assert property (@(posedge clk) disable iff (rst)
        (loc_valid && loc_stall) |=> !loc_ack);

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .loc_valid(loc_valid),
    .loc_stall(loc_stall),
    .loc_addr (loc_addr),
    .loc_ack  (loc_ack),
    .loc_hit  (loc_hit),
    .loc_state(loc_state),
    .snp_ack  (snp_ack),
    .snp_retry(snp_retry),
    .bus_valid(bus_valid),
    .bus_op   (bus_op),
    .bus_addr (bus_addr)
);

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          loc_valid = 1'b0, loc_write = 1'b0;
    logic [AW-1:0] loc_addr = '0;
    logic          snp_valid = 1'b0, snp_inval = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          loc_stall, loc_ack, loc_hit, snp_ack, snp_hit, snp_retry, bus_valid;
    logic [1:0]    loc_state, bus_op;
    logic [AW-1:0] bus_addr;

    int n_checks = 0;
    int n_fail   = 0;

    // state and bus codes (R2)
    localparam logic [1:0] I = 2'b00, S = 2'b01, E = 2'b10, M = 2'b11;
    localparam logic [1:0] NONE = 2'b00, FILL = 2'b01, WT = 2'b10, WB = 2'b11;

    always #2 clk = ~clk;

    mesi_line_ctrl #(.ADDR_W(AW), .NUM_LINES(8)) u_mesi_line_ctrl (
        .clk(clk), .rst(rst),
        .loc_valid(loc_valid), .loc_write(loc_write), .loc_addr(loc_addr),
        .loc_stall(loc_stall), .loc_ack(loc_ack), .loc_hit(loc_hit), .loc_state(loc_state),
        .snp_valid(snp_valid), .snp_inval(snp_inval), .snp_addr(snp_addr),
        .snp_ack(snp_ack), .snp_hit(snp_hit), .snp_retry(snp_retry),
        .bus_valid(bus_valid), .bus_op(bus_op), .bus_addr(bus_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one local access; returns at accept edge + 1 with inputs already released at the next negedge
    task automatic do_local(input logic w, input logic [AW-1:0] a,
                            output logic ack, output logic hit, output logic [1:0] st,
                            output logic bv, output logic [1:0] op, output logic [AW-1:0] ba);
        @(negedge clk);
        loc_valid = 1'b1; loc_write = w; loc_addr = a;
        @(posedge clk); #1;
        ack = loc_ack; hit = loc_hit; st = loc_state; bv = bus_valid; op = bus_op; ba = bus_addr;
        @(negedge clk);
        loc_valid = 1'b0;
    endtask

    task automatic do_snoop(input logic inv, input logic [AW-1:0] a,
                            output logic ack, output logic hit, output logic rty, output logic bv);
        @(negedge clk);
        snp_valid = 1'b1; snp_inval = inv; snp_addr = a;
        @(posedge clk); #1;
        ack = snp_ack; hit = snp_hit; rty = snp_retry; bv = bus_valid;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // local access with full result check
    task automatic local_expect(input string req, input logic w, input logic [AW-1:0] a,
                                input logic ehit, input logic [1:0] est,
                                input logic ebv, input logic [1:0] eop, input logic [AW-1:0] eba);
        logic ack, hit, bv;
        logic [1:0] st, op;
        logic [AW-1:0] ba;
        do_local(w, a, ack, hit, st, bv, op, ba);
        chk({req, " ack"}, 32'(ack), 32'd1);
        chk({req, " hit"}, 32'(hit), 32'(ehit));
        chk({req, " state"}, 32'(st), 32'(est));
        chk({req, " bus_valid"}, 32'(bv), 32'(ebv));
        chk({req, " bus_op"}, 32'(op), 32'(eop));
        if (ebv) chk({req, " bus_addr"}, 32'(ba), 32'(eba));
    endtask

    task automatic snoop_expect(input string req, input logic inv, input logic [AW-1:0] a,
                                input logic ehit, input logic erty);
        logic ack, hit, rty, bv;
        do_snoop(inv, a, ack, hit, rty, bv);
        chk({req, " snp_ack"}, 32'(ack), 32'd1);
        chk({req, " snp_hit"}, 32'(hit), 32'(ehit));
        chk({req, " snp_retry"}, 32'(rty), 32'(erty));
        chk({req, " bus_valid"}, 32'(bv), 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 bus_valid", 32'(bus_valid), 32'd0);
        chk("R1 loc_ack", 32'(loc_ack), 32'd0);
        chk("R1 snp_ack", 32'(snp_ack), 32'd0);
        chk("R1 snp_retry", 32'(snp_retry), 32'd0);
        chk("R2 bus_op idle", 32'(bus_op), 32'(NONE));
        local_expect("R1/R5 first read miss", 1'b0, 12'h005, 1'b0, E, 1'b1, FILL, 12'h005);
        local_expect("R1 other line invalid", 1'b0, 12'h006, 1'b0, E, 1'b1, FILL, 12'h006);
    endtask

    task automatic t_hits;
        local_expect("R3 read E", 1'b0, 12'h005, 1'b1, E, 1'b0, NONE, '0);
        local_expect("R4 write E->M", 1'b1, 12'h005, 1'b1, M, 1'b0, NONE, '0);
        local_expect("R4 write M", 1'b1, 12'h005, 1'b1, M, 1'b0, NONE, '0);
        local_expect("R3 read M", 1'b0, 12'h005, 1'b1, M, 1'b0, NONE, '0);
    endtask

    task automatic t_snoop_dirty;
        @(negedge clk);
        snp_valid = 1'b1; snp_inval = 1'b0; snp_addr = 12'h005;
        @(posedge clk); #1;
        chk("R8 snp_ack", 32'(snp_ack), 32'd1);
        chk("R8 snp_hit", 32'(snp_hit), 32'd1);
        chk("R8 retry first", 32'(snp_retry), 32'd1);
        chk("R8/R12 no bus yet", 32'(bus_valid), 32'd0);
        @(negedge clk);
        loc_valid = 1'b1; loc_write = 1'b0; loc_addr = 12'h005;
        #1;
        chk("R10 stall while wb pending", 32'(loc_stall), 32'd1);
        @(posedge clk); #1;
        chk("R8 wb issued", 32'(bus_valid), 32'd1);
        chk("R8 wb op", 32'(bus_op), 32'(WB));
        chk("R8 wb addr", 32'(bus_addr), 32'h005);
        chk("R8/R11 retry second", 32'(snp_retry), 32'd1);
        chk("R11 refused snoop not acked", 32'(snp_ack), 32'd0);
        chk("R10 no local ack", 32'(loc_ack), 32'd0);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk("R10 stall released", 32'(loc_stall), 32'd0);
        @(posedge clk); #1;
        chk("R8 line now shared", 32'(loc_state), 32'(S));
        chk("R8 local hit", 32'(loc_hit), 32'd1);
        chk("R3 read S silent", 32'(bus_valid), 32'd0);
        @(negedge clk);
        loc_valid = 1'b0;
    endtask

    task automatic t_shared_exclusive;
        snoop_expect("R7 snoop read S", 1'b0, 12'h005, 1'b1, 1'b0);
        local_expect("R7 still S", 1'b0, 12'h005, 1'b1, S, 1'b0, NONE, '0);
        local_expect("R4 write S->E wt", 1'b1, 12'h005, 1'b1, E, 1'b1, WT, 12'h005);
        snoop_expect("R7 snoop read E", 1'b0, 12'h005, 1'b1, 1'b0);
        local_expect("R7 E became S", 1'b0, 12'h005, 1'b1, S, 1'b0, NONE, '0);
    endtask

    task automatic t_invalidate;
        snoop_expect("R9 inval hit S", 1'b1, 12'h005, 1'b1, 1'b0);
        local_expect("R9 line invalid", 1'b0, 12'h005, 1'b0, E, 1'b1, FILL, 12'h005);
        snoop_expect("R7 snoop miss other tag", 1'b1, 12'h105, 1'b0, 1'b0);
        local_expect("R7 miss left line", 1'b0, 12'h005, 1'b1, E, 1'b0, NONE, '0);
        local_expect("R9 prep M", 1'b1, 12'h005, 1'b1, M, 1'b0, NONE, '0);
        snoop_expect("R9 inval hit M", 1'b1, 12'h005, 1'b1, 1'b0);
        local_expect("R9 M invalidated", 1'b0, 12'h005, 1'b0, E, 1'b1, FILL, 12'h005);
    endtask

    task automatic t_write_miss;
        local_expect("R6 write miss empty", 1'b1, 12'h013, 1'b0, I, 1'b1, WT, 12'h013);
        local_expect("R6 not allocated", 1'b0, 12'h013, 1'b0, E, 1'b1, FILL, 12'h013);
        local_expect("R6 write miss conflict", 1'b1, 12'h113, 1'b0, I, 1'b1, WT, 12'h113);
        local_expect("R6 resident unchanged", 1'b0, 12'h013, 1'b1, E, 1'b0, NONE, '0);
    endtask

    task automatic t_victim;
        local_expect("R5 prep M", 1'b1, 12'h013, 1'b1, M, 1'b0, NONE, '0);
        local_expect("R5 victim wb first", 1'b0, 12'h113, 1'b0, E, 1'b1, WB, 12'h013);
        @(posedge clk); #1;
        chk("R5 fill follows", 32'(bus_valid), 32'd1);
        chk("R5 fill op", 32'(bus_op), 32'(FILL));
        chk("R5 fill addr", 32'(bus_addr), 32'h113);
        local_expect("R5 clean victim", 1'b0, 12'h013, 1'b0, E, 1'b1, FILL, 12'h013);
    endtask

    task automatic t_collision;
        @(negedge clk);
        snp_valid = 1'b1; snp_inval = 1'b0; snp_addr = 12'h007;
        loc_valid = 1'b1; loc_write = 1'b0; loc_addr = 12'h007;
        #1;
        chk("R10 stall on snoop", 32'(loc_stall), 32'd1);
        @(posedge clk); #1;
        chk("R10 snoop first", 32'(snp_ack), 32'd1);
        chk("R7 snoop miss", 32'(snp_hit), 32'd0);
        chk("R10 local held", 32'(loc_ack), 32'd0);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk("R10 stall gone", 32'(loc_stall), 32'd0);
        @(posedge clk); #1;
        chk("R10/R12 local served", 32'(loc_ack), 32'd1);
        chk("R5 fill after stall", 32'(bus_op), 32'(FILL));
        chk("R5 fill addr", 32'(bus_addr), 32'h007);
        @(negedge clk);
        loc_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_hits();
        t_snoop_dirty();
        t_shared_exclusive();
        t_invalidate();
        t_write_miss();
        t_victim();
        t_collision();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule